// File: doc/BRIEF.md
# Multibit Trie Longest-Prefix Lookup Engine

This block resolves a 32-bit destination address to a next-hop code by walking a multibit trie held in on-chip node memory. The address is consumed from its most significant end, one stride of 8 bits per level, so a lookup costs at most four node reads instead of the thirty-two a one-bit-per-level trie would need. Each node is a row of 256 slots; the slot selected by the current stride says whether a next hop is attached at this depth and whether a child node continues the path.

While walking, the engine keeps the deepest next hop it has seen and stops at the first slot without a child, or after the fourth level. The answer is that retained next hop, or a miss indication when the path carried none. Prefixes whose length is not a multiple of the stride are expanded by the table loader into several slots before they are written through the simple write port; the engine itself only ever stores whole-stride prefixes.

Requests arrive over a valid/ready handshake, one lookup is processed at a time, and the result stays on the response port until it is acknowledged.

Top module: `trie_lpm_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1; `req_ready` then stays 0 until the response has been acknowledged, and returns to 1 on the edge after `rsp_valid` and `rsp_ready` are both 1.
- R3: The walk starts at node 0; at level L (0..3) it reads the slot whose index is address bits [31-8L : 24-8L] inside the current node, and moves to the slot's child pointer on the next level.
- R4: A write with `wr_en` high stores child pointer, child-valid, next hop and next-hop-valid into the slot addressed by `wr_addr` = node number times 256 plus slot index; later lookups see the new contents.
- R5: The returned next hop is the one in the deepest slot on the path whose next-hop-valid bit is set.
- R6: The walk ends after reading a slot whose child-valid bit is 0; `rsp_levels` reports how many slots were read.
- R7: The walk ends after the fourth read even if that slot has child-valid set; `rsp_levels` never exceeds 4.
- R8: If no slot on the path had next-hop-valid set, `rsp_miss` is 1 and `rsp_hop` is 0; otherwise `rsp_miss` is 0.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_hop`, `rsp_miss` and `rsp_levels` do not change.
- R10: Each level costs exactly two cycles: `rsp_valid` first shows 2 x `rsp_levels` clock edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Store one node slot |
| wr_addr | input | 11 | Node number (upper 3 bits) and slot index (lower 8 bits) |
| wr_child | input | 3 | Child node pointer for the slot |
| wr_child_ok | input | 1 | Child pointer is valid |
| wr_hop | input | 8 | Next-hop code for the slot |
| wr_hop_ok | input | 1 | Next-hop code is valid |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | 32 | Destination address to resolve |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result acknowledged |
| rsp_hop | output | 8 | Resolved next hop, 0 on a miss |
| rsp_miss | output | 1 | No prefix matched |
| rsp_levels | output | 3 | Number of node slots read |

## Verification
The bench aims at the path where an intermediate slot carries a next hop and a deeper slot carries none, which a design that only looks at the final slot would report as a miss. It sets child-valid on a fourth-level slot to catch an engine that walks past the last level or lets the address index run off its end, and it builds a path that dies at level two to catch an engine that ignores child-valid. Held-off acknowledges check that the result registers are not overwritten, and the latency count catches an engine that shortens or stretches a level, while a large random table with random addresses exercises every depth and index combination against a bench model of the trie.

// File: rtl/trie_pkg.sv
// Shared definitions for the multibit trie lookup engine.
// Assumes: only the walk state encoding is shared between modules.
package trie_pkg;
    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_ISSUE = 2'd1,
        WALK_WAIT  = 2'd2,
        WALK_DONE  = 2'd3
    } walk_state_e;
endpackage

// File: rtl/trie_node_mem.sv
// Node slot storage: one write port, one read port with one cycle latency.
// Assumes: contents are not reset; the loader writes every slot it relies on.
module trie_node_mem #(
    parameter int ADDR_BITS = 11,
    parameter int DATA_W    = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int DEPTH = 1 << ADDR_BITS;

    logic [DATA_W-1:0] slots [DEPTH];

    // Store a slot from the loader.
    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_addr] <= wr_data;
    end

    // Registered read for the walker.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= slots[rd_addr];
    end

    // R10: every read is followed by a cycle spent consuming its data
    rd_issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
endmodule

// File: rtl/trie_walker.sv
// Walk control: takes a request, reads one slot per level, keeps the
// deepest valid next hop and holds the result until acknowledged.
// Assumes: slot layout {child ptr, child ok, hop, hop ok}, MSB first.
module trie_walker
    import trie_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int STRIDE    = 8,
    parameter int NODE_BITS = 3,
    parameter int HOP_W     = 8,
    localparam int LEVELS   = ADDR_W / STRIDE,
    localparam int LVL_W    = $clog2(LEVELS + 1),
    localparam int MEM_AW   = NODE_BITS + STRIDE,
    localparam int ENTRY_W  = NODE_BITS + HOP_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [HOP_W-1:0]   rsp_hop,
    output logic               rsp_miss,
    output logic [LVL_W-1:0]   rsp_levels,
    output logic               rd_en,
    output logic [MEM_AW-1:0]  rd_addr,
    input  logic [ENTRY_W-1:0] rd_data
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_e            state;
    logic [ADDR_W-1:0]      key;
    logic [NODE_BITS-1:0]   node;
    logic [LVL_W-1:0]       level;
    logic [HOP_W-1:0]       best_hop;
    logic                   best_ok;

    logic                   ent_hop_ok;
    logic [HOP_W-1:0]       ent_hop;
    logic                   ent_child_ok;
    logic [NODE_BITS-1:0]   ent_child;
    logic                   descend;

    // Split the slot just read into its fields.
    always_comb begin
        ent_hop_ok   = rd_data[0];
        ent_hop      = rd_data[HOP_W:1];
        ent_child_ok = rd_data[HOP_W+1];
        ent_child    = rd_data[ENTRY_W-1 -: NODE_BITS];
        descend      = ent_child_ok && (level != LAST_LVL);
    end

    // Address the slot chosen by the current stride in the current node.
    always_comb begin
        rd_en   = (state == WALK_ISSUE);
        rd_addr = {node, key[ADDR_W-1 -: STRIDE]};
    end

    assign req_ready = (state == WALK_IDLE);
    assign rsp_valid = (state == WALK_DONE);

    // Walk sequencing, best-match tracking and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= WALK_IDLE;
            key        <= '0;
            node       <= '0;
            level      <= '0;
            best_hop   <= '0;
            best_ok    <= 1'b0;
            rsp_hop    <= '0;
            rsp_miss   <= 1'b0;
            rsp_levels <= '0;
        end else begin
            unique case (state)
                WALK_IDLE: begin
                    if (req_valid) begin
                        key     <= req_addr;
                        node    <= '0;
                        level   <= '0;
                        best_ok <= 1'b0;
                        state   <= WALK_ISSUE;
                    end
                end
                WALK_ISSUE: state <= WALK_WAIT;
                WALK_WAIT: begin
                    if (ent_hop_ok) begin
                        best_hop <= ent_hop;
                        best_ok  <= 1'b1;
                    end
                    if (descend) begin
                        node  <= ent_child;
                        level <= level + 1'b1;
                        key   <= key << STRIDE;
                        state <= WALK_ISSUE;
                    end else begin
                        rsp_levels <= level + 1'b1;
                        rsp_miss   <= !(ent_hop_ok || best_ok);
                        rsp_hop    <= ent_hop_ok ? ent_hop :
                                      (best_ok ? best_hop : '0);
                        state      <= WALK_DONE;
                    end
                end
                WALK_DONE: begin
                    if (rsp_ready) state <= WALK_IDLE;
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hop)
            && $stable(rsp_miss) && $stable(rsp_levels));
    // R2
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> req_ready);
    // R7
    depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_levels >= LVL_W'(1)) && (rsp_levels <= LVL_W'(LEVELS)));
    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_miss |-> rsp_hop == '0);
endmodule

// File: rtl/trie_lpm_engine.sv
// Top of the multibit trie longest-prefix lookup: node memory plus walker.
// Assumes: the loader has expanded prefixes to whole strides and writes
// while no lookup depends on the slots being changed.
module trie_lpm_engine #(
    parameter int ADDR_W    = 32,
    parameter int STRIDE    = 8,
    parameter int NODE_BITS = 3,
    parameter int HOP_W     = 8,
    localparam int LEVELS   = ADDR_W / STRIDE,
    localparam int LVL_W    = $clog2(LEVELS + 1),
    localparam int MEM_AW   = NODE_BITS + STRIDE,
    localparam int ENTRY_W  = NODE_BITS + HOP_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [MEM_AW-1:0]    wr_addr,
    input  logic [NODE_BITS-1:0] wr_child,
    input  logic                 wr_child_ok,
    input  logic [HOP_W-1:0]     wr_hop,
    input  logic                 wr_hop_ok,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [HOP_W-1:0]     rsp_hop,
    output logic                 rsp_miss,
    output logic [LVL_W-1:0]     rsp_levels
);
    logic               rd_en;
    logic [MEM_AW-1:0]  rd_addr;
    logic [ENTRY_W-1:0] rd_data;
    logic [ENTRY_W-1:0] wr_data;

    // Pack the loader's fields into the slot layout.
    assign wr_data = {wr_child, wr_child_ok, wr_hop, wr_hop_ok};

    trie_node_mem #(
        .ADDR_BITS (MEM_AW),
        .DATA_W    (ENTRY_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    trie_walker #(
        .ADDR_W    (ADDR_W),
        .STRIDE    (STRIDE),
        .NODE_BITS (NODE_BITS),
        .HOP_W     (HOP_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_hop    (rsp_hop),
        .rsp_miss   (rsp_miss),
        .rsp_levels (rsp_levels),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );
endmodule

// File: tb/trie_lpm_engine_test.sv
`timescale 1ns/1ps
// Bench: directed trie paths plus a random table and random addresses,
// compared against a bench model of the walk.
module trie_lpm_engine_test;
    localparam int SLOTS = 2048;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [2:0]  wr_child = '0;
    logic        wr_child_ok = 1'b0;
    logic [7:0]  wr_hop = '0;
    logic        wr_hop_ok = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [7:0]  rsp_hop;
    logic        rsp_miss;
    logic [2:0]  rsp_levels;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [12:0] model [SLOTS];

    trie_lpm_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_child(wr_child), .wr_child_ok(wr_child_ok), .wr_hop(wr_hop),
        .wr_hop_ok(wr_hop_ok), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_hop(rsp_hop), .rsp_miss(rsp_miss), .rsp_levels(rsp_levels)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // R4: one slot write through the port, mirrored in the model.
    task automatic put(input int idx, input logic [2:0] ch, input logic cok,
                       input logic [7:0] hop, input logic hok);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 11'(idx); wr_child = ch;
        wr_child_ok = cok; wr_hop = hop; wr_hop_ok = hok;
        model[idx] = {ch, cok, hop, hok};
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Reference walk from the requirements (R3, R5..R8).
    function automatic void ref_walk(input logic [31:0] a, output logic [7:0] hop,
                                     output logic miss, output int lv);
        int node = 0;
        logic [12:0] e;
        hop = '0; miss = 1'b1; lv = 0;
        for (int l = 0; l < 4; l++) begin
            e = model[node*256 + int'(a[31-8*l -: 8])];
            lv = l + 1;
            if (e[0]) begin hop = e[8:1]; miss = 1'b0; end
            if (!e[9] || l == 3) break;
            node = int'(e[12:10]);
        end
    endfunction

    task automatic lookup(input logic [31:0] a, input int hold);
        logic [7:0] ehop; logic emiss; int elv; int cyc;
        logic [7:0] h0; logic m0; logic [2:0] l0;
        ref_walk(a, ehop, emiss, elv);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; rsp_ready = 1'b0;
        check(req_ready == 1'b1, "R2 idle ready", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        // R2: busy after acceptance
        check(req_ready == 1'b0, "R2 busy", req_ready, 0);
        while (!rsp_valid && cyc < 40) begin
            @(posedge clk); cyc++; @(negedge clk);
        end
        check(cyc == 2*elv, "R10 latency", cyc, 2*elv);
        check(rsp_hop == ehop, "R5 hop", rsp_hop, ehop);
        check(rsp_miss == emiss, "R8 miss", rsp_miss, emiss);
        check(int'(rsp_levels) == elv, "R6 R7 levels", rsp_levels, elv);
        h0 = rsp_hop; m0 = rsp_miss; l0 = rsp_levels;
        for (int i = 0; i < hold; i++) begin
            @(posedge clk); @(negedge clk);
            check(rsp_valid && rsp_hop == h0 && rsp_miss == m0 && rsp_levels == l0,
                  "R9 hold", {rsp_valid, rsp_hop, rsp_miss, rsp_levels},
                  {1'b1, h0, m0, l0});
        end
        check(req_ready == 1'b0, "R2 busy until ack", req_ready, 0);
        rsp_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && req_ready, "R2 ack release", {rsp_valid, req_ready}, 2'b01);
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset",
              {req_ready, rsp_valid}, 2'b10);
        for (int i = 0; i < SLOTS; i++) put(i, 3'd0, 1'b0, 8'd0, 1'b0);

        // R8 R6: empty table misses after one read
        lookup(32'h12345678, 0);
        // R3 R7: four-level chain, child-valid on last slot ignored
        put(0*256 + 8'h0A, 3'd1, 1'b1, 8'h00, 1'b0);
        put(1*256 + 8'h14, 3'd2, 1'b1, 8'h33, 1'b1);
        put(2*256 + 8'h1E, 3'd3, 1'b1, 8'h00, 1'b0);
        put(3*256 + 8'h28, 3'd4, 1'b1, 8'h77, 1'b1);
        put(4*256 + 8'h00, 3'd5, 1'b1, 8'hEE, 1'b1);
        lookup(32'h0A141E28, 5);
        // R5: deeper slot without hop keeps the level-two hop
        lookup(32'h0A141E29, 2);
        // R6 R8: path dies at level two with no hop seen
        lookup(32'h0A150000, 0);
        // R4: rewrite changes the answer
        put(3*256 + 8'h28, 3'd0, 1'b0, 8'h5A, 1'b1);
        lookup(32'h0A141E28, 0);

        // Random table and addresses
        for (int i = 0; i < SLOTS; i++)
            put(i, 3'($urandom), ($urandom % 10) < 7, 8'($urandom) | 8'h01,
                ($urandom % 10) < 4);
        for (int n = 0; n < 300; n++)
            lookup($urandom, int'($urandom % 4));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule